// File: doc/BRIEF.md
# Legacy INTx Virtual-Wire Aggregator

This block merges legacy level-style interrupt wires that arrive as paired assert and deassert messages from several downstream ports. Each port tracks its own copy of the four interrupt lines A, B, C and D, and a one-bit state per port and line records whether that port currently holds the line asserted. For every line the block ORs the unmasked per-port bits into one combined level. It tells an upstream I/O controller about that level with a single assert or deassert message, sent only when the combined level actually changes.

Incoming messages are already decoded. Each is a one-cycle strobe carrying a port number, a line number and an assert/deassert flag. Software can write a per-port, per-line mask that removes a port's bit from the OR. It can read every per-port bit, every mask bit, the four combined levels and two sticky protocol-error flags. Upstream messages leave through a valid/ready handshake. Level changes that happen while the output is stalled are queued per line and then sent in the fixed priority order A, B, C, D.

Top module: `intx_aggregator`

## Requirements
- R1: While reset is active and in the first cycle after it, all per-port bits, mask bits, combined levels and error flags read 0, and `up_valid` is low.
- R2: A message with `msg_assert`=1 sets status bit `stat_port_bits[port*4+line]`, and one with `msg_assert`=0 clears it. The new value is visible in the cycle after the strobe edge. Line codes are 0=A, 1=B, 2=C, 3=D.
- R3: An assert for a bit that is already set raises `stat_err_dup`, and a deassert for a bit that is already clear raises `stat_err_orphan`. In both cases the bit is left unchanged. Both flags stay set until reset.
- R4: `stat_line_level[l]` is the OR over all ports of `stat_port_bits[p*4+l]` with masked bits excluded. It follows the per-port bits in the same cycle.
- R5: A strobe on `cfg_mask_we` loads `cfg_mask_data` into the four mask bits of port `cfg_mask_port`, shown at `stat_mask_bits[p*4+l]`. A set mask bit removes that port's bit from the OR, and masking or unmasking counts as a level change.
- R6: A 0-to-1 change of a combined level produces a message with `up_assert`=1, and a 1-to-0 change produces one with `up_assert`=0. `up_valid` rises one clock after the combined level changes. An assert or deassert that leaves the combined level unchanged produces no message.
- R7: When several lines have queued messages and no message is on hold, the lowest line code is offered first.
- R8: While `up_valid` is high and `up_ready` is low, `up_line` and `up_assert` stay stable. Level changes that occur during the stall are queued, and each one is delivered later in order.
- R9: Each line queues at most 2^PEND_W-1 changes (7 by default). A change that arrives when the queue is full cancels the newest queued change, so the queue then holds one change fewer and the last level delivered still matches the combined level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | Decoded interrupt message strobe |
| msg_port | input | PORT_W (2) | Source port number |
| msg_line | input | 2 | Line code 0=A..3=D |
| msg_assert | input | 1 | 1 = assert, 0 = deassert |
| cfg_mask_we | input | 1 | Mask write strobe |
| cfg_mask_port | input | PORT_W (2) | Port whose mask is written |
| cfg_mask_data | input | 4 | New mask bits, bit l = line l |
| up_valid | output | 1 | Upstream message offered |
| up_ready | input | 1 | Upstream accepts the message |
| up_line | output | 2 | Line code of the offered message |
| up_assert | output | 1 | 1 = assert message, 0 = deassert |
| stat_port_bits | output | NUM_PORTS*4 (16) | Per-port line state, bit p*4+l |
| stat_mask_bits | output | NUM_PORTS*4 (16) | Per-port line mask, bit p*4+l |
| stat_line_level | output | 4 | Combined level per line |
| stat_err_dup | output | 1 | Sticky duplicate-assert flag |
| stat_err_orphan | output | 1 | Sticky orphan-deassert flag |

## Verification
A strobe or mask write sampled at a rising edge shows in the status outputs after that same edge. The upstream message it causes is counted at the following edge, so `up_valid` becomes visible two edges after the strobe. A handshake at an edge exposes the next queued message right after that edge. The bench drives and samples on falling edges, with one idle cycle after each strobe task before it looks at the upstream side. Whenever it expects no message, it waits past that two-edge window before checking.

// File: rtl/intx_pkg.sv
package intx_pkg;
  localparam int INTX_LINES = 4;
  localparam int LINE_W     = 2;

  typedef enum logic [LINE_W-1:0] {
    INTX_A = 2'd0,
    INTX_B = 2'd1,
    INTX_C = 2'd2,
    INTX_D = 2'd3
  } intx_line_e;

  // Lowest set request index; A has the highest priority.
  function automatic logic [LINE_W-1:0] lowest_set(logic [INTX_LINES-1:0] req);
    logic [LINE_W-1:0] idx;
    idx = '0;
    for (int i = INTX_LINES - 1; i >= 0; i--) begin
      if (req[i]) idx = LINE_W'(i);
    end
    return idx;
  endfunction

  // Next queued-change count: a grant removes one, a level change adds one,
  // and a change into a full queue cancels the newest queued change.
  function automatic int pend_next(int cnt, logic chg, logic take, int cap);
    int n;
    n = take ? cnt - 1 : cnt;
    if (chg) n = (n == cap) ? n - 1 : n + 1;
    return n;
  endfunction
endpackage

// File: rtl/intx_port_track.sv
module intx_port_track
  import intx_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  hit,
  input  logic [LINE_W-1:0]     line,
  input  logic                  is_assert,
  input  logic                  mask_we,
  input  logic [INTX_LINES-1:0] mask_wdata,
  output logic [INTX_LINES-1:0] state,
  output logic [INTX_LINES-1:0] mask,
  output logic                  dup_evt,
  output logic                  orphan_evt
);
  logic [INTX_LINES-1:0] line_hit;

  for (genvar l = 0; l < INTX_LINES; l++) begin : g_line
    assign line_hit[l] = hit && (line == LINE_W'(l));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        state[l] <= 1'b0;
      end else if (line_hit[l]) begin
        if (is_assert && !state[l])      state[l] <= 1'b1;
        else if (!is_assert && state[l]) state[l] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       mask <= '0;
    else if (mask_we) mask <= mask_wdata;
  end

  assign dup_evt    = is_assert  && |(line_hit & state);
  assign orphan_evt = !is_assert && |(line_hit & ~state);
endmodule

// File: rtl/intx_line_queue.sv
module intx_line_queue
  import intx_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int PEND_W    = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PORTS-1:0] contrib,
  input  logic                 take,
  output logic                 level,
  output logic                 level_q,
  output logic                 change,
  output logic                 sent_lvl,
  output logic                 pending,
  output logic [PEND_W-1:0]    cnt
);
  localparam int CAP = (1 << PEND_W) - 1;

  assign level   = |contrib;
  assign change  = level ^ level_q;
  assign pending = (cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level_q  <= 1'b0;
      sent_lvl <= 1'b0;
      cnt      <= '0;
    end else begin
      level_q <= level;
      cnt     <= PEND_W'(pend_next(int'(cnt), change, take, CAP));
      if (take) sent_lvl <= ~sent_lvl;
    end
  end
endmodule

// File: rtl/intx_up_arb.sv
module intx_up_arb
  import intx_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [INTX_LINES-1:0] pending,
  input  logic [INTX_LINES-1:0] sent_lvl,
  input  logic                  up_ready,
  output logic                  up_valid,
  output logic [LINE_W-1:0]     up_line,
  output logic                  up_assert,
  output logic [INTX_LINES-1:0] take
);
  logic              held_q;
  intx_line_e        held_line_q;
  intx_line_e        pick;

  assign pick      = held_q ? held_line_q : intx_line_e'(lowest_set(pending));
  assign up_valid  = |pending;
  assign up_line   = pick;
  assign up_assert = ~sent_lvl[pick];
  assign take      = (up_valid && up_ready) ? (INTX_LINES'(1) << pick) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q      <= 1'b0;
      held_line_q <= INTX_A;
    end else begin
      held_q      <= up_valid && !up_ready;
      held_line_q <= pick;
    end
  end
endmodule

// File: rtl/intx_aggregator.sv
module intx_aggregator
  import intx_pkg::*;
#(
  parameter  int NUM_PORTS = 4,
  parameter  int PEND_W    = 3,
  localparam int PORT_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int STAT_W    = NUM_PORTS * INTX_LINES
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  msg_valid,
  input  logic [PORT_W-1:0]     msg_port,
  input  logic [LINE_W-1:0]     msg_line,
  input  logic                  msg_assert,
  input  logic                  cfg_mask_we,
  input  logic [PORT_W-1:0]     cfg_mask_port,
  input  logic [INTX_LINES-1:0] cfg_mask_data,
  output logic                  up_valid,
  input  logic                  up_ready,
  output logic [LINE_W-1:0]     up_line,
  output logic                  up_assert,
  output logic [STAT_W-1:0]     stat_port_bits,
  output logic [STAT_W-1:0]     stat_mask_bits,
  output logic [INTX_LINES-1:0] stat_line_level,
  output logic                  stat_err_dup,
  output logic                  stat_err_orphan
);
  logic [NUM_PORTS-1:0]                  dup_vec;
  logic [NUM_PORTS-1:0]                  orphan_vec;
  logic [INTX_LINES-1:0][NUM_PORTS-1:0]  line_contrib;
  logic [INTX_LINES-1:0]                 line_take;
  logic [INTX_LINES-1:0]                 lvl_q;
  logic [INTX_LINES-1:0]                 line_change;
  logic [INTX_LINES-1:0]                 sent_lvl;
  logic [INTX_LINES-1:0]                 line_pend;
  logic [INTX_LINES-1:0][PEND_W-1:0]     pend_cnt;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic hit;
    logic mhit;
    assign hit  = msg_valid   && (msg_port      == PORT_W'(p));
    assign mhit = cfg_mask_we && (cfg_mask_port == PORT_W'(p));

    intx_port_track u_track (
      .clk        (clk),
      .rst_n      (rst_n),
      .hit        (hit),
      .line       (msg_line),
      .is_assert  (msg_assert),
      .mask_we    (mhit),
      .mask_wdata (cfg_mask_data),
      .state      (stat_port_bits[p*INTX_LINES +: INTX_LINES]),
      .mask       (stat_mask_bits[p*INTX_LINES +: INTX_LINES]),
      .dup_evt    (dup_vec[p]),
      .orphan_evt (orphan_vec[p])
    );

    for (genvar l = 0; l < INTX_LINES; l++) begin : g_contrib
      assign line_contrib[l][p] = stat_port_bits[p*INTX_LINES + l]
                                & ~stat_mask_bits[p*INTX_LINES + l];
    end
  end

  for (genvar l = 0; l < INTX_LINES; l++) begin : g_line
    intx_line_queue #(
      .NUM_PORTS (NUM_PORTS),
      .PEND_W    (PEND_W)
    ) u_queue (
      .clk      (clk),
      .rst_n    (rst_n),
      .contrib  (line_contrib[l]),
      .take     (line_take[l]),
      .level    (stat_line_level[l]),
      .level_q  (lvl_q[l]),
      .change   (line_change[l]),
      .sent_lvl (sent_lvl[l]),
      .pending  (line_pend[l]),
      .cnt      (pend_cnt[l])
    );
  end

  intx_up_arb u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .pending   (line_pend),
    .sent_lvl  (sent_lvl),
    .up_ready  (up_ready),
    .up_valid  (up_valid),
    .up_line   (up_line),
    .up_assert (up_assert),
    .take      (line_take)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_err_dup    <= 1'b0;
      stat_err_orphan <= 1'b0;
    end else begin
      if (|dup_vec)    stat_err_dup    <= 1'b1;
      if (|orphan_vec) stat_err_orphan <= 1'b1;
    end
  end
endmodule

// File: rtl/intx_aggregator_chk.sv
module intx_aggregator_chk
  import intx_pkg::*;
#(
  parameter  int NUM_PORTS = 4,
  parameter  int PEND_W    = 3,
  localparam int PORT_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int STAT_W    = NUM_PORTS * INTX_LINES
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic                              msg_valid,
  input logic [PORT_W-1:0]                 msg_port,
  input logic [LINE_W-1:0]                 msg_line,
  input logic                              msg_assert,
  input logic [STAT_W-1:0]                 stat_port_bits,
  input logic                              stat_err_dup,
  input logic                              stat_err_orphan,
  input logic                              up_valid,
  input logic                              up_ready,
  input logic [LINE_W-1:0]                 up_line,
  input logic                              up_assert,
  input logic [INTX_LINES-1:0]             line_take,
  input logic [INTX_LINES-1:0]             lvl_q,
  input logic [INTX_LINES-1:0]             sent_lvl,
  input logic [INTX_LINES-1:0]             line_change,
  input logic [INTX_LINES-1:0][PEND_W-1:0] pend_cnt
);
  logic [PORT_W+LINE_W-1:0] msg_idx;
  assign msg_idx = {msg_port, msg_line};

  AST_ASSERT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_assert |=> stat_port_bits[$past(msg_idx)]); // R2
  AST_DEASSERT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_assert |=> !stat_port_bits[$past(msg_idx)]); // R2
  AST_DUP_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_assert && stat_port_bits[msg_idx] |=> stat_err_dup); // R3
  AST_DUP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    stat_err_dup |=> stat_err_dup); // R3
  AST_ORPHAN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    stat_err_orphan |=> stat_err_orphan); // R3
  AST_TAKE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(line_take)); // R7
  AST_PAYLOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid && !up_ready |=> up_valid && $stable(up_line) && $stable(up_assert)); // R8

  for (genvar l = 0; l < INTX_LINES; l++) begin : g_line_chk
    AST_QUEUE_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
      pend_cnt[l][0] == (lvl_q[l] ^ sent_lvl[l])); // R9
    AST_CHANGE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      line_change[l] |=> pend_cnt[l] != '0); // R8
  end
endmodule

bind intx_aggregator intx_aggregator_chk #(
  .NUM_PORTS (NUM_PORTS),
  .PEND_W    (PEND_W)
) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .msg_valid       (msg_valid),
  .msg_port        (msg_port),
  .msg_line        (msg_line),
  .msg_assert      (msg_assert),
  .stat_port_bits  (stat_port_bits),
  .stat_err_dup    (stat_err_dup),
  .stat_err_orphan (stat_err_orphan),
  .up_valid        (up_valid),
  .up_ready        (up_ready),
  .up_line         (up_line),
  .up_assert       (up_assert),
  .line_take       (line_take),
  .lvl_q           (lvl_q),
  .sent_lvl        (sent_lvl),
  .line_change     (line_change),
  .pend_cnt        (pend_cnt)
);

// File: tb/test_intx_aggregator.sv
`timescale 1ns/1ps
module test_intx_aggregator;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        msg_valid = 1'b0;
  logic [1:0]  msg_port = '0;
  logic [1:0]  msg_line = '0;
  logic        msg_assert = 1'b0;
  logic        cfg_mask_we = 1'b0;
  logic [1:0]  cfg_mask_port = '0;
  logic [3:0]  cfg_mask_data = '0;
  logic        up_valid;
  logic        up_ready = 1'b0;
  logic [1:0]  up_line;
  logic        up_assert;
  logic [15:0] stat_port_bits;
  logic [15:0] stat_mask_bits;
  logic [3:0]  stat_line_level;
  logic        stat_err_dup;
  logic        stat_err_orphan;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  intx_aggregator i_intx_aggregator (
    .clk (clk), .rst_n (rst_n),
    .msg_valid (msg_valid), .msg_port (msg_port), .msg_line (msg_line),
    .msg_assert (msg_assert),
    .cfg_mask_we (cfg_mask_we), .cfg_mask_port (cfg_mask_port),
    .cfg_mask_data (cfg_mask_data),
    .up_valid (up_valid), .up_ready (up_ready), .up_line (up_line),
    .up_assert (up_assert),
    .stat_port_bits (stat_port_bits), .stat_mask_bits (stat_mask_bits),
    .stat_line_level (stat_line_level),
    .stat_err_dup (stat_err_dup), .stat_err_orphan (stat_err_orphan)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  // All tasks start and end at a falling edge.
  task automatic send(int p, int l, bit a);
    msg_valid = 1'b1; msg_port = 2'(p); msg_line = 2'(l); msg_assert = a;
    step();
    msg_valid = 1'b0;
  endtask

  task automatic set_mask(int p, logic [3:0] m);
    cfg_mask_we = 1'b1; cfg_mask_port = 2'(p); cfg_mask_data = m;
    step();
    cfg_mask_we = 1'b0;
  endtask

  task automatic take(string req, int l, bit a);
    check(req, "up_valid", 32'(up_valid), 32'd1);
    check(req, "up_line", 32'(up_line), 32'(l));
    check(req, "up_assert", 32'(up_assert), 32'(a));
    up_ready = 1'b1;
    step();
    up_ready = 1'b0;
  endtask

  task automatic t_reset();
    step(3);
    check("R1", "port bits in reset", 32'(stat_port_bits), 0);
    check("R1", "valid in reset", 32'(up_valid), 0);
    rst_n = 1'b1;
    step();
    check("R1", "mask bits", 32'(stat_mask_bits), 0);
    check("R1", "levels", 32'(stat_line_level), 0);
    check("R1", "errors", 32'({stat_err_dup, stat_err_orphan}), 0);
    check("R1", "valid after reset", 32'(up_valid), 0);
  endtask

  task automatic t_basic();
    send(0, 0, 1'b1);
    check("R2", "bit 0 set", 32'(stat_port_bits[0]), 1);
    check("R4", "level A", 32'(stat_line_level[0]), 1);
    check("R6", "valid not yet", 32'(up_valid), 0);
    step();
    take("R6", 0, 1'b1);
    check("R6", "queue empty", 32'(up_valid), 0);
    send(0, 0, 1'b0);
    check("R2", "bit 0 clear", 32'(stat_port_bits[0]), 0);
    step();
    take("R6", 0, 1'b0);
  endtask

  task automatic t_shared();
    send(1, 2, 1'b1);
    step();
    take("R6", 2, 1'b1);
    send(2, 2, 1'b1);
    check("R2", "bit 10 set", 32'(stat_port_bits[10]), 1);
    step(2);
    check("R6", "second assert silent", 32'(up_valid), 0);
    send(1, 2, 1'b0);
    check("R4", "level C held by port 2", 32'(stat_line_level[2]), 1);
    step(2);
    check("R6", "first deassert silent", 32'(up_valid), 0);
    send(2, 2, 1'b0);
    check("R4", "level C low", 32'(stat_line_level[2]), 0);
    step();
    take("R6", 2, 1'b0);
  endtask

  task automatic t_errors();
    check("R3", "no error yet", 32'({stat_err_dup, stat_err_orphan}), 0);
    send(3, 1, 1'b1);
    send(3, 1, 1'b1);
    check("R3", "dup flag", 32'(stat_err_dup), 1);
    check("R3", "bit 13 kept", 32'(stat_port_bits[13]), 1);
    take("R3", 1, 1'b1);
    check("R3", "dup no extra msg", 32'(up_valid), 0);
    check("R3", "dup sticky", 32'(stat_err_dup), 1);
    send(3, 1, 1'b0);
    step();
    take("R3", 1, 1'b0);
    check("R3", "orphan clear", 32'(stat_err_orphan), 0);
    send(3, 1, 1'b0);
    check("R3", "orphan flag", 32'(stat_err_orphan), 1);
    check("R3", "bit 13 still clear", 32'(stat_port_bits[13]), 0);
    step(2);
    check("R3", "orphan no msg", 32'(up_valid), 0);
    check("R3", "orphan sticky", 32'(stat_err_orphan), 1);
  endtask

  task automatic t_mask();
    send(3, 1, 1'b1);
    step();
    take("R5", 1, 1'b1);
    set_mask(3, 4'b0010);
    check("R5", "mask bit 13", 32'(stat_mask_bits[13]), 1);
    check("R5", "level B masked", 32'(stat_line_level[1]), 0);
    check("R5", "state kept", 32'(stat_port_bits[13]), 1);
    step();
    take("R5", 1, 1'b0);
    set_mask(3, 4'b0000);
    check("R5", "level B back", 32'(stat_line_level[1]), 1);
    step();
    take("R5", 1, 1'b1);
    send(3, 1, 1'b0);
    step();
    take("R5", 1, 1'b0);
  endtask

  task automatic t_priority();
    set_mask(0, 4'b1111);
    send(0, 3, 1'b1);
    send(0, 1, 1'b1);
    send(0, 0, 1'b1);
    step();
    check("R5", "masked silent", 32'(up_valid), 0);
    check("R4", "masked levels", 32'(stat_line_level), 0);
    set_mask(0, 4'b0000);
    check("R4", "levels A B D", 32'(stat_line_level), 32'hb);
    step();
    take("R7", 0, 1'b1);
    take("R7", 1, 1'b1);
    take("R7", 3, 1'b1);
    check("R7", "drained", 32'(up_valid), 0);
    send(0, 0, 1'b0);
    send(0, 1, 1'b0);
    send(0, 3, 1'b0);
    step();
    take("R7", 0, 1'b0);
    take("R7", 1, 1'b0);
    take("R7", 3, 1'b0);
  endtask

  task automatic t_stall();
    send(0, 3, 1'b1);
    step();
    check("R8", "D offered", 32'(up_line), 3);
    send(1, 0, 1'b1);
    step(2);
    check("R8", "line held", 32'(up_line), 3);
    check("R8", "kind held", 32'(up_assert), 1);
    take("R8", 3, 1'b1);
    take("R8", 0, 1'b1);
    send(0, 3, 1'b0);
    send(1, 0, 1'b0);
    step();
    take("R8", 3, 1'b0);
    take("R8", 0, 1'b0);
    check("R8", "drained", 32'(up_valid), 0);
  endtask

  task automatic t_overflow();
    for (int k = 0; k < 4; k++) begin
      send(0, 0, 1'b1);
      send(0, 0, 1'b0);
    end
    step();
    for (int k = 0; k < 6; k++) take("R9", 0, (k % 2) == 0);
    check("R9", "six delivered", 32'(up_valid), 0);
    check("R9", "level A low", 32'(stat_line_level[0]), 0);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_shared();
    t_errors();
    t_mask();
    t_priority();
    t_stall();
    t_overflow();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule